// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a synchronous DRAM from the moment its clock starts to the point where it can accept normal traffic. It owns the memory command pins for that whole interval. After reset it keeps the clock-enable and data-mask pins high and sends only no-operation commands for a settling time. The settling time is a number of microseconds, turned into clock cycles by a clock-frequency parameter.

Once the device has settled, the block sends one precharge that closes every bank. It then sends two groups of commands, in an order set by a parameter. One group is a configurable number of auto-refresh commands. The other is a single mode-register load. Each command is followed by a parameterized gap filled with no-operations.

The mode-register word is built at elaboration time from four parameters: burst length, burst ordering, CAS latency and write-burst behaviour. When the last gap has elapsed, a ready flag goes high and stays high until the next reset. The memory controller that shares the pins takes over from that point.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the command is NOP, clock enable is 1, data mask is 1, ready is 0, and the address and bank outputs are 0. Commands are encoded on {cmd_sel_n, cmd_row_n, cmd_col_n, cmd_wr_n} as NOP=0111, PRECHARGE=0010, AUTO REFRESH=0001 and MODE LOAD=0000.
- R2: After reset, exactly CLK_MHZ*SETTLE_US consecutive cycles carry NOP, counting the first cycle after reset as cycle 0. The precharge comes in the next cycle.
- R3: Exactly one precharge is sent. During it mem_addr has only bit 10 set (all banks), and mem_bank is 0.
- R4: The first command after the precharge comes T_RP cycles after it, with NOP in every cycle between them.
- R5: Exactly REFRESH_COUNT auto-refresh commands are sent (REFRESH_COUNT must be at least 2). Each is followed by T_RFC cycles before the next command, with NOP in every cycle between.
- R6: Exactly one mode-load command is sent, with mem_bank 0. When REF_BEFORE_MRS=1 it follows the refresh group. When REF_BEFORE_MRS=0 it comes directly after the precharge gap, and the refresh group follows it.
- R7: During the mode load, mem_addr[2:0] is the burst code (length 1=000, 2=001, 4=010, 8=011, full page, written as BURST_LEN=0, =111). mem_addr[3] is 1 for interleaved order. mem_addr[6:4] is the CAS latency (2=010, 3=011). mem_addr[8:7] is 00. mem_addr[9] is 1 for single-location writes. All higher bits are 0.
- R8: The first command, or ready, after the mode load comes T_MRD cycles after it, with NOP in every cycle between.
- R9: Ready rises exactly one gap length (T_RFC or T_MRD) after the final command, and then stays high with NOP until reset. Data mask drops to 0 when ready rises. Clock enable is 1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_sel_n | output | 1 | Command bit 3, chip select (active low) |
| cmd_row_n | output | 1 | Command bit 2, row strobe (active low) |
| cmd_col_n | output | 1 | Command bit 1, column strobe (active low) |
| cmd_wr_n | output | 1 | Command bit 0, write enable (active low) |
| clk_en | output | 1 | Memory clock enable, held 1 |
| data_mask | output | 1 | Data mask, 1 until ready |
| mem_addr | output | ADDR_W | Address bus (all-bank flag or mode word) |
| mem_bank | output | BANK_W | Bank select, 0 throughout |
| ready | output | 1 | Initialization finished, sticky until reset |

## Verification
The bench builds two instances side by side. Both use CLK_MHZ=1 and SETTLE_US=20, which shrinks the settling wait to 20 cycles, so the whole sequence fits in a short capture window.

The first instance puts three refreshes before the mode load and uses gaps of 3/5/2 cycles. It also sets length 8, interleaved order, latency 2 and single-location writes. The second instance loads the mode first, then two refreshes. It uses gaps of 2/4/3 cycles and sets full page, sequential order, latency 3 and burst writes.

Between them the two instances cover both command orders, both ways ready can be reached, the minimum gap of 2, and every active bit of the mode word. A second reset after ready is also applied.

// File: rtl/sdram_init_pkg.sv
// Shared types for the SDRAM power-up sequencer.
// Assumes a single-rank SDRAM command set on four active-low pins.
package sdram_init_pkg;

    // Command codes on {select, row strobe, column strobe, write}
    typedef enum logic [3:0] {
        CMD_MODE = 4'b0000,
        CMD_REF  = 4'b0001,
        CMD_PRE  = 4'b0010,
        CMD_NOP  = 4'b0111
    } sdram_cmd_e;

    typedef enum logic [2:0] {
        ST_SETTLE,
        ST_PRE,
        ST_PRE_GAP,
        ST_REF,
        ST_REF_GAP,
        ST_MODE,
        ST_MODE_GAP,
        ST_READY
    } init_state_e;

    // Burst length to its 3-bit code; 0 stands for full page
    function automatic logic [2:0] burst_code(input int len);
        case (len)
            1:       return 3'b000;
            2:       return 3'b001;
            4:       return 3'b010;
            8:       return 3'b011;
            default: return 3'b111;
        endcase
    endfunction

endpackage

// File: rtl/sdram_init_timer.sv
// Down-counter used for every wait of the sequencer.
// It comes out of reset holding RESET_VAL, so the settling wait starts by itself.
// A load sets a new value. The counter stops at zero, and 'zero' flags that state.
module sdram_init_timer #(
    parameter int CNT_W     = 16,
    parameter int RESET_VAL = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt;

    // Count down towards zero, reload on request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= CNT_W'(RESET_VAL);
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

    // R4: an expired timer stays expired until reloaded
    a_r4_timer_stays_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero);

endmodule

// File: rtl/sdram_mode_word.sv
// Builds the mode-register word from elaboration-time parameters.
// Assumes ADDR_W >= 10. Unused and reserved bits are driven 0.
module sdram_mode_word
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W           = 12,
    parameter int BURST_LEN        = 8,
    parameter bit BURST_INTERLEAVE = 1'b0,
    parameter int CAS_LAT          = 3,
    parameter bit SINGLE_WRITE     = 1'b0
) (
    output logic [ADDR_W-1:0] word
);

    localparam logic [2:0] BL_CODE  = burst_code(BURST_LEN);
    localparam logic [2:0] CAS_CODE = 3'(CAS_LAT);

    // Place each field; the bits from 10 upward stay zero
    always_comb begin
        word      = '0;
        word[2:0] = BL_CODE;
        word[3]   = BURST_INTERLEAVE;
        word[6:4] = CAS_CODE;
        word[8:7] = 2'b00;
        word[9]   = SINGLE_WRITE;
    end

endmodule

// File: rtl/sdram_init_fsm.sv
// Command-order state machine for the power-up sequence.
// The order is: settle, precharge, then refresh group and mode load in the
// order REF_BEFORE_MRS selects, then ready.
// Assumes every gap (T_RP, T_RFC, T_MRD) is at least 2 and REFRESH_COUNT >= 2.
// Each command state loads the timer with gap-2, so the next command comes
// exactly 'gap' cycles later.
module sdram_init_fsm
    import sdram_init_pkg::*;
#(
    parameter int CNT_W          = 16,
    parameter int REFRESH_COUNT  = 2,
    parameter bit REF_BEFORE_MRS = 1'b1,
    parameter int T_RP           = 3,
    parameter int T_RFC          = 8,
    parameter int T_MRD          = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output sdram_cmd_e       cmd,
    output logic             done
);

    localparam int REF_W = $clog2(REFRESH_COUNT + 1);

    init_state_e      state;
    logic [REF_W-1:0] ref_left;

    // Step through the sequence and count the refreshes still owed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_SETTLE;
            ref_left <= REF_W'(REFRESH_COUNT);
        end else begin
            case (state)
                ST_SETTLE:   if (tmr_zero) state <= ST_PRE;
                ST_PRE:      state <= ST_PRE_GAP;
                ST_PRE_GAP:  if (tmr_zero) state <= REF_BEFORE_MRS ? ST_REF : ST_MODE;
                ST_REF: begin
                    ref_left <= ref_left - 1'b1;
                    state    <= ST_REF_GAP;
                end
                ST_REF_GAP:  if (tmr_zero) begin
                    if (ref_left != '0)      state <= ST_REF;
                    else if (REF_BEFORE_MRS) state <= ST_MODE;
                    else                     state <= ST_READY;
                end
                ST_MODE:     state <= ST_MODE_GAP;
                ST_MODE_GAP: if (tmr_zero) state <= REF_BEFORE_MRS ? ST_READY : ST_REF;
                default:     state <= ST_READY;
            endcase
        end
    end

    // Decode the command and the timer reload for each state
    always_comb begin
        cmd      = CMD_NOP;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state)
            ST_PRE:  begin cmd = CMD_PRE;  tmr_load = 1'b1; tmr_val = CNT_W'(T_RP - 2);  end
            ST_REF:  begin cmd = CMD_REF;  tmr_load = 1'b1; tmr_val = CNT_W'(T_RFC - 2); end
            ST_MODE: begin cmd = CMD_MODE; tmr_load = 1'b1; tmr_val = CNT_W'(T_MRD - 2); end
            default: ;
        endcase
    end

    assign done = (state == ST_READY);

    // R5: a refresh is only ever sent while one is still owed
    a_r5_ref_budget: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REF) |-> (ref_left != '0));

    // R9: ready is sticky until reset
    a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

endmodule

// File: rtl/sdram_pwrup_seq.sv
// SDRAM power-up initialization sequencer (top).
// It drives the memory command pins from reset until the device is ready.
// Assumes CLK_MHZ*SETTLE_US >= 1, every gap >= 2, REFRESH_COUNT >= 2, ADDR_W >= 11.
module sdram_pwrup_seq
    import sdram_init_pkg::*;
#(
    parameter int CLK_MHZ          = 100,
    parameter int SETTLE_US        = 200,
    parameter int REFRESH_COUNT    = 2,
    parameter bit REF_BEFORE_MRS   = 1'b1,
    parameter int T_RP             = 3,
    parameter int T_RFC            = 8,
    parameter int T_MRD            = 2,
    parameter int BURST_LEN        = 8,
    parameter bit BURST_INTERLEAVE = 1'b0,
    parameter int CAS_LAT          = 3,
    parameter bit SINGLE_WRITE     = 1'b0,
    parameter int ADDR_W           = 12,
    parameter int BANK_W           = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              cmd_sel_n,
    output logic              cmd_row_n,
    output logic              cmd_col_n,
    output logic              cmd_wr_n,
    output logic              clk_en,
    output logic              data_mask,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BANK_W-1:0] mem_bank,
    output logic              ready
);

    localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
    localparam int GAP_MAX    = (T_RP > T_RFC) ? ((T_RP > T_MRD) ? T_RP : T_MRD)
                                               : ((T_RFC > T_MRD) ? T_RFC : T_MRD);
    localparam int CNT_MAX    = (SETTLE_CYC > GAP_MAX) ? SETTLE_CYC : GAP_MAX;
    localparam int CNT_W      = $clog2(CNT_MAX + 1);
    localparam int ALL_BANK   = 10;

    logic             tmr_zero;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    sdram_cmd_e       cmd;
    logic             done;
    logic [ADDR_W-1:0] mode_word;

    sdram_init_timer #(
        .CNT_W     (CNT_W),
        .RESET_VAL (SETTLE_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    sdram_init_fsm #(
        .CNT_W          (CNT_W),
        .REFRESH_COUNT  (REFRESH_COUNT),
        .REF_BEFORE_MRS (REF_BEFORE_MRS),
        .T_RP           (T_RP),
        .T_RFC          (T_RFC),
        .T_MRD          (T_MRD)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tmr_zero (tmr_zero),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .cmd      (cmd),
        .done     (done)
    );

    sdram_mode_word #(
        .ADDR_W           (ADDR_W),
        .BURST_LEN        (BURST_LEN),
        .BURST_INTERLEAVE (BURST_INTERLEAVE),
        .CAS_LAT          (CAS_LAT),
        .SINGLE_WRITE     (SINGLE_WRITE)
    ) u_mode (
        .word (mode_word)
    );

    // Drive the pins: command code, all-bank flag or mode word, static enables
    always_comb begin
        {cmd_sel_n, cmd_row_n, cmd_col_n, cmd_wr_n} = cmd;
        mem_addr = '0;
        if (cmd == CMD_PRE)  mem_addr[ALL_BANK] = 1'b1;
        if (cmd == CMD_MODE) mem_addr = mode_word;
    end

    assign mem_bank  = '0;
    assign clk_en    = 1'b1;
    assign data_mask = ~done;
    assign ready     = done;

    // R4/R5/R8: every command is followed by at least one NOP
    a_r4_cmd_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NOP) |=> (cmd == CMD_NOP));

    // R9: once ready, the pins stay quiet
    a_r9_quiet_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> (cmd == CMD_NOP && mem_addr == '0));

    // R9: ready never rises in the same cycle as a command
    a_r9_rise_on_nop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (cmd == CMD_NOP && $past(cmd) == CMD_NOP));

endmodule

// File: tb/sdram_pwrup_seq_tb.sv
// Directed bench for sdram_pwrup_seq: two instances, one for each command order.
module sdram_pwrup_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 12;
    localparam int NCAP       = 64;

    // Instance A: refresh group first
    localparam int A_SETTLE = 20, A_NREF = 3, A_TRP = 3, A_TRFC = 5, A_TMRD = 2;
    // Instance B: mode load first
    localparam int B_SETTLE = 20, B_NREF = 2, B_TRP = 2, B_TRFC = 4, B_TMRD = 3;

    localparam logic [3:0] C_NOP = 4'b0111, C_PRE = 4'b0010,
                           C_REF = 4'b0001, C_MODE = 4'b0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [3:0]        cmd_a, cmd_b;
    logic              cke_a, cke_b, dqm_a, dqm_b, rdy_a, rdy_b;
    logic [ADDR_W-1:0] addr_a, addr_b;
    logic [0:0]        ba_a, ba_b;

    sdram_pwrup_seq #(
        .CLK_MHZ(1), .SETTLE_US(20), .REFRESH_COUNT(A_NREF), .REF_BEFORE_MRS(1'b1),
        .T_RP(A_TRP), .T_RFC(A_TRFC), .T_MRD(A_TMRD), .BURST_LEN(8),
        .BURST_INTERLEAVE(1'b1), .CAS_LAT(2), .SINGLE_WRITE(1'b1),
        .ADDR_W(ADDR_W), .BANK_W(1)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_sel_n(cmd_a[3]), .cmd_row_n(cmd_a[2]), .cmd_col_n(cmd_a[1]), .cmd_wr_n(cmd_a[0]),
        .clk_en(cke_a), .data_mask(dqm_a), .mem_addr(addr_a), .mem_bank(ba_a), .ready(rdy_a)
    );

    sdram_pwrup_seq #(
        .CLK_MHZ(1), .SETTLE_US(20), .REFRESH_COUNT(B_NREF), .REF_BEFORE_MRS(1'b0),
        .T_RP(B_TRP), .T_RFC(B_TRFC), .T_MRD(B_TMRD), .BURST_LEN(0),
        .BURST_INTERLEAVE(1'b0), .CAS_LAT(3), .SINGLE_WRITE(1'b0),
        .ADDR_W(ADDR_W), .BANK_W(1)
    ) u_dut_b (
        .clk(clk), .rst_n(rst_n),
        .cmd_sel_n(cmd_b[3]), .cmd_row_n(cmd_b[2]), .cmd_col_n(cmd_b[1]), .cmd_wr_n(cmd_b[0]),
        .clk_en(cke_b), .data_mask(dqm_b), .mem_addr(addr_b), .mem_bank(ba_b), .ready(rdy_b)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [3:0]        got_cmd  [2][NCAP];
    logic [ADDR_W-1:0] got_addr [2][NCAP];
    logic              got_ba   [2][NCAP];
    logic              got_rdy  [2][NCAP];
    logic              got_dqm  [2][NCAP];
    logic              got_cke  [2][NCAP];
    logic [3:0]        exp_cmd  [2][NCAP];
    string             exp_tag  [2][NCAP];
    int                pre_at [2];
    int                mode_at[2];
    int                rdy_at [2];

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 5000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 5000);
            finish_run();
        end
    end

    // Expected schedule worked out from R2..R9
    task automatic build_expect(input int i, input int settle, input int nref,
                                input bit ref_first, input int trp,
                                input int trfc, input int tmrd);
        int t;
        for (int c = 0; c < NCAP; c++) begin
            exp_cmd[i][c] = C_NOP;
            exp_tag[i][c] = (c < settle) ? "R2" : "R9";
        end
        t = settle;
        pre_at[i] = t; exp_cmd[i][t] = C_PRE; exp_tag[i][t] = "R3";
        for (int g = 1; g < trp; g++) exp_tag[i][t+g] = "R4";
        t += trp;
        if (!ref_first) begin
            mode_at[i] = t; exp_cmd[i][t] = C_MODE; exp_tag[i][t] = "R6";
            for (int g = 1; g < tmrd; g++) exp_tag[i][t+g] = "R8";
            t += tmrd;
        end
        for (int r = 0; r < nref; r++) begin
            exp_cmd[i][t] = C_REF; exp_tag[i][t] = "R5";
            for (int g = 1; g < trfc; g++) exp_tag[i][t+g] = "R5";
            t += trfc;
        end
        if (ref_first) begin
            mode_at[i] = t; exp_cmd[i][t] = C_MODE; exp_tag[i][t] = "R6";
            for (int g = 1; g < tmrd; g++) exp_tag[i][t+g] = "R8";
            t += tmrd;
        end
        rdy_at[i] = t;
    endtask

    // R1: outputs while reset is held
    task automatic t_reset_state();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(cmd_a == C_NOP, "R1", "A cmd in reset", cmd_a, C_NOP);
        check(cmd_b == C_NOP, "R1", "B cmd in reset", cmd_b, C_NOP);
        check(cke_a && cke_b, "R1", "clk_en in reset", {cke_a, cke_b}, 3);
        check(dqm_a && dqm_b, "R1", "data_mask in reset", {dqm_a, dqm_b}, 3);
        check(!rdy_a && !rdy_b, "R1", "ready in reset", {rdy_a, rdy_b}, 0);
        check(addr_a == '0 && ba_a == '0, "R1", "A addr/bank in reset", addr_a, 0);
    endtask

    // Release reset at a falling edge and record NCAP cycles (cycle 0 = this edge)
    task automatic t_capture();
        rst_n = 1'b1;
        for (int c = 0; c < NCAP; c++) begin
            if (c != 0) @(negedge clk);
            got_cmd[0][c] = cmd_a;  got_cmd[1][c] = cmd_b;
            got_addr[0][c] = addr_a; got_addr[1][c] = addr_b;
            got_ba[0][c] = ba_a[0]; got_ba[1][c] = ba_b[0];
            got_rdy[0][c] = rdy_a;  got_rdy[1][c] = rdy_b;
            got_dqm[0][c] = dqm_a;  got_dqm[1][c] = dqm_b;
            got_cke[0][c] = cke_a;  got_cke[1][c] = cke_b;
        end
    endtask

    // R2..R6, R8: the command seen in every cycle matches the schedule
    task automatic t_sequence(input int i);
        for (int c = 0; c < NCAP; c++)
            check(got_cmd[i][c] == exp_cmd[i][c], exp_tag[i][c],
                  $sformatf("inst %0d cmd at cycle %0d", i, c),
                  got_cmd[i][c], exp_cmd[i][c]);
    endtask

    // R3, R7: address and bank during precharge and mode load
    task automatic t_address(input int i, input logic [ADDR_W-1:0] mode_exp);
        check(got_addr[i][pre_at[i]] == 12'h400, "R3", $sformatf("inst %0d precharge addr", i),
              got_addr[i][pre_at[i]], 12'h400);
        check(got_ba[i][pre_at[i]] == 1'b0, "R3", $sformatf("inst %0d precharge bank", i),
              got_ba[i][pre_at[i]], 0);
        check(got_addr[i][mode_at[i]] == mode_exp, "R7", $sformatf("inst %0d mode word", i),
              got_addr[i][mode_at[i]], mode_exp);
        check(got_ba[i][mode_at[i]] == 1'b0, "R6", $sformatf("inst %0d mode bank", i),
              got_ba[i][mode_at[i]], 0);
    endtask

    // R9: ready timing, stickiness, data mask and clock enable per cycle
    task automatic t_ready(input int i);
        for (int c = 0; c < NCAP; c++) begin
            check(got_rdy[i][c] == (c >= rdy_at[i]), "R9",
                  $sformatf("inst %0d ready at cycle %0d", i, c), got_rdy[i][c], c >= rdy_at[i]);
            check(got_dqm[i][c] == (c < rdy_at[i]), "R9",
                  $sformatf("inst %0d data_mask at cycle %0d", i, c), got_dqm[i][c], c < rdy_at[i]);
            check(got_cke[i][c] == 1'b1, "R9",
                  $sformatf("inst %0d clk_en at cycle %0d", i, c), got_cke[i][c], 1);
        end
    endtask

    // R1: a reset after ready returns both instances to the start
    task automatic t_reset_again();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(!rdy_a && !rdy_b, "R1", "ready cleared by second reset", {rdy_a, rdy_b}, 0);
        check(dqm_a && dqm_b, "R1", "data_mask set by second reset", {dqm_a, dqm_b}, 3);
        rst_n = 1'b1;
        for (int c = 1; c < 6; c++) begin
            @(negedge clk);
            check(cmd_a == C_NOP && cmd_b == C_NOP, "R2", "settle NOP after second reset",
                  {cmd_a, cmd_b}, {C_NOP, C_NOP});
        end
    endtask

    initial begin
        build_expect(0, A_SETTLE, A_NREF, 1'b1, A_TRP, A_TRFC, A_TMRD);
        build_expect(1, B_SETTLE, B_NREF, 1'b0, B_TRP, B_TRFC, B_TMRD);
        t_reset_state();
        t_capture();
        t_sequence(0);
        t_sequence(1);
        // A: single write (bit9), CAS 2 (010), interleave (bit3), length 8 (011)
        t_address(0, 12'h22B);
        // B: burst write, CAS 3 (011), sequential, full page (111)
        t_address(1, 12'h037);
        t_ready(0);
        t_ready(1);
        t_reset_again();
        finish_run();
    end

endmodule